// File: doc/BRIEF.md
# Selectable PRBS Pattern Generator

This block produces a word-parallel pseudo-random test stream for link bring-up and bit-error testing. A one-hot select chooses one of four standard polynomials (PRBS7, PRBS9, PRBS23 and PRBS31) at run time. Each clock in which the generator runs yields one `WIDTH`-bit word. The bit generated first in time sits in the word's most significant position.

Generation advances only when the test enable and the pattern clock enable are both high and the select is a legal one-hot value. There is no start handshake: a word appears one clock after the block is enabled. The shift register is reseeded to all ones after reset and whenever the select changes. An active-low polarity control sends the stream inverted when it is 0, so the stream is inverted while that control sits at its reset level.

Top module: `prbs_gen`

## Requirements
- R1: The select encodes bit 0 = PRBS7 (x^7+x^6+1), bit 1 = PRBS9 (x^9+x^5+1), bit 2 = PRBS23 (x^23+x^18+1) and bit 3 = PRBS31 (x^31+x^28+1). Each bit is the XOR of state bits n-1 and t-1 (degree n, middle tap t). That bit is shifted into bit 0 of the state and is also the emitted bit.
- R2: Within a word, bit WIDTH-1 is the earliest generated bit. With PRBS7 from the all-ones seed and WIDTH=8, the first uninverted word is 8'h02.
- R3: When `true_pol` is 1 the word is output as generated, and when it is 0 every bit is inverted. The first PRBS7 word from the seed is 8'hFD with `true_pol` = 0.
- R4: If `test_en` or `pat_clk_en` is low, then one clock later `valid` is 0 and `data` is 0. The state holds, so the sequence resumes where it stopped.
- R5: If the select does not have exactly one bit set, then one clock later `valid` and `data` are 0 and the state does not advance.
- R6: A select that differs from the previous cycle's select reloads the state to all ones. That cycle gives no word: `valid` and `data` are 0 one clock later. Reset also loads all ones.
- R7: With a stable legal select and both enables high, `valid` is 1 on the clock that follows. No other handshake is needed.
- R8: During reset, `valid` and `data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poly_sel | input | 4 | One-hot polynomial select |
| test_en | input | 1 | Pattern test enable |
| pat_clk_en | input | 1 | Pattern clock enable |
| true_pol | input | 1 | Polarity: 0 inverts output, 1 passes it as generated |
| valid | output | 1 | A word was generated this cycle |
| data | output | WIDTH | Output pattern word |

## Verification
The hardest case to reach from the ports is a select change that lands while generation is gated off or the select is illegal. The reseed must still take effect, and later words must come from the new seed rather than from held state. The random stimulus changes the select, drops either enable and drives non-one-hot codes independently in every cycle, so these overlaps happen often. A directed sequence also pins the first PRBS7 words after a reseed to fixed values in both polarities.

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       poly_sel,
  input  logic             test_en,
  input  logic             pat_clk_en,
  input  logic             true_pol,
  output logic             valid,
  output logic [WIDTH-1:0] data
);
  localparam int SW = 31;
  localparam int RW = WIDTH + SW;

  logic [SW-1:0] lfsr;
  logic [3:0]    sel_q;
  logic          legal, run, reseed;
  logic [RW-1:0] nxt;

  function automatic logic [RW-1:0] advance(input logic [SW-1:0] s, input logic [3:0] sel);
    int n, t;
    logic fb;
    logic [SW-1:0] st, mask;
    logic [WIDTH-1:0] w;
    case (sel)
      4'b0001: begin n = 7;  t = 6;  end
      4'b0010: begin n = 9;  t = 5;  end
      4'b0100: begin n = 23; t = 18; end
      default: begin n = 31; t = 28; end
    endcase
    mask = {SW{1'b1}} >> (SW - n);
    st = s & mask;
    w = '0;
    for (int i = 0; i < WIDTH; i++) begin
      fb = st[n-1] ^ st[t-1];
      w[WIDTH-1-i] = fb;
      st = {st[SW-2:0], fb} & mask;
    end
    return {w, st};
  endfunction

  assign legal  = $onehot(poly_sel);
  assign reseed = poly_sel != sel_q;
  assign run    = test_en && pat_clk_en && legal && !reseed;
  assign nxt    = advance(lfsr, poly_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr  <= '1;
      sel_q <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      sel_q <= poly_sel;
      valid <= run;
      data  <= run ? (nxt[RW-1:SW] ^ {WIDTH{~true_pol}}) : '0;
      if (reseed)   lfsr <= '1;
      else if (run) lfsr <= nxt[SW-1:0];
    end
  end

  a_r5_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$onehot(poly_sel) |=> (!valid && data == '0));
  a_r4_gated_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_en && pat_clk_en) |=> (!valid && data == '0));
  a_r6_reseed_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (poly_sel != sel_q) |=> (!valid && lfsr == {SW{1'b1}}));
  a_r7_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && pat_clk_en && $onehot(poly_sel) && poly_sel == sel_q) |=> valid);
  a_r4_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!(test_en && pat_clk_en) && poly_sel == sel_q) |=> $stable(lfsr));
  a_r1_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

// File: tb/prbs_gen_tb.sv
module prbs_gen_tb_top;
  localparam int WIDTH = 8;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] poly_sel = 0;
  logic test_en = 0, pat_clk_en = 0, true_pol = 0;
  logic valid;
  logic [WIDTH-1:0] data;

  int checks = 0, fails = 0;
  logic [30:0] m_state;
  logic [3:0]  m_sel;
  logic        e_valid;
  logic [WIDTH-1:0] e_data;
  string       e_tag;

  prbs_gen #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .test_en(test_en),
    .pat_clk_en(pat_clk_en), .true_pol(true_pol), .valid(valid), .data(data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [WIDTH:0] act, logic [WIDTH:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int deg(logic [3:0] s);
    return s[0] ? 7 : s[1] ? 9 : s[2] ? 23 : 31;
  endfunction
  function automatic int tap(logic [3:0] s);
    return s[0] ? 6 : s[1] ? 5 : s[2] ? 18 : 28;
  endfunction

  task automatic model();
    int n, t;
    logic b;
    e_valid = 0; e_data = '0;
    if (poly_sel != m_sel) begin
      m_sel = poly_sel; m_state = '1; e_tag = "R6";
    end else if ($countones(poly_sel) != 1) begin
      e_tag = "R5";
    end else if (!(test_en && pat_clk_en)) begin
      e_tag = "R4";
    end else begin
      e_tag = "R1";
      n = deg(poly_sel); t = tap(poly_sel);
      e_valid = 1;
      for (int i = 0; i < WIDTH; i++) begin
        b = m_state[n-1] ^ m_state[t-1];
        e_data = {e_data[WIDTH-2:0], b};
        m_state = {m_state[29:0], b};
        for (int k = n; k < 31; k++) m_state[k] = 1'b0;
      end
      if (!true_pol) e_data = ~e_data;
    end
  endtask

  task automatic cycle();
    model();
    @(posedge clk); #1;
    check(e_tag, {valid, data}, {e_valid, e_data});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8", {valid, data}, '0);
    rst_n = 1;
    m_sel = 0; m_state = '1;

    poly_sel = 4'b0001; test_en = 1; pat_clk_en = 1; true_pol = 1;
    cycle(); check("R6", {1'b0, valid}, 2'b00);
    cycle(); check("R7", {1'b0, valid}, 2'b01);
    check("R2", {1'b0, data}, {1'b0, 8'h02});
    poly_sel = 4'b0010; cycle();
    poly_sel = 4'b0001; true_pol = 0; cycle();
    cycle(); check("R3", {valid, data}, {1'b1, 8'hFD});
    test_en = 0; cycle(); check("R4", {valid, data}, '0);
    test_en = 1; pat_clk_en = 0; cycle();
    pat_clk_en = 1; cycle();
    poly_sel = 4'b0011; cycle(); check("R5", {valid, data}, '0);
    poly_sel = 4'b0000; cycle();
    poly_sel = 4'b1000; cycle();
    repeat (5) cycle();

    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4) poly_sel = 4'(1 << $urandom_range(0, 3));
      else if (r < 6) poly_sel = 4'($urandom_range(0, 15));
      test_en    = $urandom_range(0, 9) != 0;
      pat_clk_en = $urandom_range(0, 9) != 0;
      if ($urandom_range(0, 9) == 0) true_pol = ~true_pol;
      cycle();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule